// File: doc/BRIEF.md
# Sign-Magnitude Shift-and-Add Multiplier

This block multiplies two sign-magnitude numbers over several clock cycles. Each operand is a sign bit plus a magnitude of `WIDTH-1` bits. The result is a sign bit plus a magnitude of `2*(WIDTH-1)` bits. The magnitude comes out in two halves: `prod_hi` holds the upper half and `prod_lo` holds the lower half.

Operands enter through a valid/ready pair. A transfer happens on a rising clock edge where both `in_valid` and `in_ready` are high. `in_ready` is high exactly when the block is idle, so a producer that holds `in_valid` waits until the running product is finished. The result side has no back-pressure. `done` is a single-cycle strobe, and the product stays on its outputs until the next transfer is accepted.

Inside, the block keeps the following registers:
- an accumulator with its own sign bit;
- a carry flip-flop;
- the multiplicand register;
- the multiplier register, which also receives the low half of the product;
- a step counter.

Each magnitude bit takes two cycles. In the first cycle, the multiplicand is added into the accumulator when the multiplier's lowest bit is 1. In the second cycle, the chain carry, accumulator, multiplier is shifted right by one place.

Top module: `smul_seq`

## Requirements
- R1: After reset, `busy` and `done` are 0, `in_ready` is 1, and `prod_sign`, `prod_hi` and `prod_lo` are all 0.
- R2: A transfer is accepted on a rising edge where `in_valid` and `in_ready` are both 1. From the next cycle on, `busy` is 1 and `in_ready` is 0.
- R3: While `busy` is 1, `in_valid` and the operand inputs are ignored. The result and the number of `done` strobes are those of the operand pair that was accepted.
- R4: `prod_sign` equals `mcand_sign` XOR `mplier_sign` of the accepted pair. This holds even when either magnitude is zero: a zero product keeps a sign of 1 when exactly one input sign is 1.
- R5: When `done` is 1, `{prod_hi, prod_lo}` equals `mcand_mag * mplier_mag` as an unsigned number of `2*(WIDTH-1)` bits. The internal carry flip-flop is 0 at that time.
- R6: `done` rises exactly `2*(WIDTH-1)` clock edges after the accepting edge, and `busy` stays 1 for all of those cycles.
- R7: `done` is high for exactly one cycle. While idle with no transfer, `prod_sign`, `prod_hi` and `prod_lo` hold their values.
- R8: A transfer offered in the same cycle as `done` is accepted at once, so back-to-back products have no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair is offered |
| in_ready | output | 1 | Block is idle and can take an operand pair |
| mcand_sign | input | 1 | Multiplicand sign (1 = negative) |
| mcand_mag | input | WIDTH-1 | Multiplicand magnitude |
| mplier_sign | input | 1 | Multiplier sign (1 = negative) |
| mplier_mag | input | WIDTH-1 | Multiplier magnitude |
| busy | output | 1 | A product is being computed |
| done | output | 1 | One-cycle strobe: the product is ready |
| prod_sign | output | 1 | Product sign |
| prod_hi | output | WIDTH-1 | Upper half of the product magnitude |
| prod_lo | output | WIDTH-1 | Lower half of the product magnitude |

## Verification
The assertions check the following on every cycle:
- an accepted transfer turns `busy` on;
- the two copies of the product sign agree and do not change mid-run;
- `done` never lasts two cycles, and the carry is clear when it fires;
- the result holds while idle;
- a counter confirms that every run takes exactly `2*(WIDTH-1)` steps.

Only the bench scenarios can show that the magnitudes are arithmetically correct. The bench covers every multiplicand against a spread of multipliers, all four sign pairings and negative zero. It also shows that offers made mid-run are dropped and that back-to-back transfers work.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADD   = 2'd1,
    ST_SHIFT = 2'd2
  } smul_state_e;
endpackage

// File: rtl/smul_adder.sv
// Ripple-carry adder for magnitude accumulation; carry-out feeds the E flop.
module smul_adder #(
  parameter int W = 7
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] c;
  assign c[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i]   = x[i] ^ y[i] ^ c[i];
    assign c[i+1]   = (x[i] & y[i]) | (c[i] & (x[i] ^ y[i]));
  end
  assign cout = c[W];
endmodule

// File: rtl/smul_ctrl.sv
// Sequencer: idle, then alternating add and shift phases, one pair per magnitude bit.
module smul_ctrl
  import smul_pkg::*;
#(
  parameter int MAG = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  output logic add_en,
  output logic shift_en,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(MAG + 1);

  smul_state_e    state;
  logic [CW-1:0]  sc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      sc    <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state <= ST_ADD;
            sc    <= CW'(MAG);
          end
        end
        ST_ADD: state <= ST_SHIFT;
        ST_SHIFT: begin
          sc <= sc - 1'b1;
          if (sc == CW'(1)) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            state <= ST_ADD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign add_en   = (state == ST_ADD);
  assign shift_en = (state == ST_SHIFT);
endmodule

// File: rtl/smul_datapath.sv
// Registers B, A, Q, E and the two sign copies; conditional add and E-A-Q shift.
module smul_datapath #(
  parameter int MAG = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           add_en,
  input  logic           shift_en,
  input  logic           b_sign,
  input  logic [MAG-1:0] b_mag,
  input  logic           q_sign,
  input  logic [MAG-1:0] q_mag,
  output logic           acc_sign,
  output logic           mq_sign,
  output logic [MAG-1:0] acc_mag,
  output logic [MAG-1:0] mq_mag,
  output logic           carry
);
  localparam int CHAIN = 2 * MAG + 1;

  logic [MAG-1:0]   b_r, a_r, q_r;
  logic             e_r, as_r, qs_r;
  logic [MAG-1:0]   sum;
  logic             cout;
  logic [CHAIN-1:0] chain_sh;

  smul_adder #(.W(MAG)) u_add (
    .x    (a_r),
    .y    (b_r),
    .sum  (sum),
    .cout (cout)
  );

  assign chain_sh = {e_r, a_r, q_r} >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_r  <= '0;
      a_r  <= '0;
      q_r  <= '0;
      e_r  <= 1'b0;
      as_r <= 1'b0;
      qs_r <= 1'b0;
    end else if (load) begin
      b_r  <= b_mag;
      q_r  <= q_mag;
      a_r  <= '0;
      e_r  <= 1'b0;
      as_r <= b_sign ^ q_sign;
      qs_r <= b_sign ^ q_sign;
    end else if (add_en) begin
      if (q_r[0]) begin
        a_r <= sum;
        e_r <= cout;
      end
    end else if (shift_en) begin
      e_r <= chain_sh[CHAIN-1];
      a_r <= chain_sh[CHAIN-2:MAG];
      q_r <= chain_sh[MAG-1:0];
    end
  end

  assign acc_sign = as_r;
  assign mq_sign  = qs_r;
  assign acc_mag  = a_r;
  assign mq_mag   = q_r;
  assign carry    = e_r;
endmodule

// File: rtl/smul_seq.sv
// Top: sign-magnitude shift-and-add multiplier with valid/ready operand intake.
module smul_seq #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             mcand_sign,
  input  logic [WIDTH-2:0] mcand_mag,
  input  logic             mplier_sign,
  input  logic [WIDTH-2:0] mplier_mag,
  output logic             busy,
  output logic             done,
  output logic             prod_sign,
  output logic [WIDTH-2:0] prod_hi,
  output logic [WIDTH-2:0] prod_lo
);
  localparam int MAG = WIDTH - 1;

  logic accept, add_en, shift_en;
  logic e_bit, qs_bit;

  assign in_ready = ~busy;
  assign accept   = in_valid & in_ready;

  smul_ctrl #(.MAG(MAG)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .add_en   (add_en),
    .shift_en (shift_en),
    .busy     (busy),
    .done     (done)
  );

  smul_datapath #(.MAG(MAG)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .add_en   (add_en),
    .shift_en (shift_en),
    .b_sign   (mcand_sign),
    .b_mag    (mcand_mag),
    .q_sign   (mplier_sign),
    .q_mag    (mplier_mag),
    .acc_sign (prod_sign),
    .mq_sign  (qs_bit),
    .acc_mag  (prod_hi),
    .mq_mag   (prod_lo),
    .carry    (e_bit)
  );
endmodule

// File: rtl/smul_seq_chk.sv
module smul_seq_chk #(
  parameter int MAG = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic           busy,
  input logic           done,
  input logic           prod_sign,
  input logic [MAG-1:0] prod_hi,
  input logic [MAG-1:0] prod_lo,
  input logic           e_bit,
  input logic           qs_bit
);
  localparam int LW = $clog2(2 * MAG + 1) + 1;

  logic [LW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  run_cnt <= '0;
    else if (in_valid && in_ready) run_cnt <= '0;
    else if (busy)               run_cnt <= run_cnt + 1'b1;
  end

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (busy && !in_ready));

  // R3
  sign_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(prod_sign));

  // R4
  sign_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prod_sign == qs_bit);

  // R5
  carry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !e_bit);

  // R6
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_cnt == LW'(2 * MAG)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(in_valid && in_ready)) |=>
      ($stable(prod_hi) && $stable(prod_lo) && $stable(prod_sign)));
endmodule

bind smul_seq smul_seq_chk #(.MAG(MAG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .busy      (busy),
  .done      (done),
  .prod_sign (prod_sign),
  .prod_hi   (prod_hi),
  .prod_lo   (prod_lo),
  .e_bit     (e_bit),
  .qs_bit    (qs_bit)
);

// File: tb/smul_seq_bench.sv
module smul_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WIDTH = 8;
  localparam int MAG = WIDTH - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic mcand_sign = 1'b0, mplier_sign = 1'b0;
  logic [MAG-1:0] mcand_mag = '0, mplier_mag = '0;
  logic busy, done, prod_sign;
  logic [MAG-1:0] prod_hi, prod_lo;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smul_seq #(.WIDTH(WIDTH)) u_smul_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .mcand_sign(mcand_sign), .mcand_mag(mcand_mag),
    .mplier_sign(mplier_sign), .mplier_mag(mplier_mag),
    .busy(busy), .done(done), .prod_sign(prod_sign),
    .prod_hi(prod_hi), .prod_lo(prod_lo)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Offer one pair at a negedge while idle; wait for done; check result and latency.
  // If junk_cycles > 0, drive other operands with in_valid high for that many busy cycles (R3).
  task automatic run_op(input logic sa, input int ma, input logic sb, input int mb,
                        input int junk_cycles);
    int cycles = 0;
    int dones = 0;
    int prod = ma * mb;
    in_valid    = 1'b1;
    mcand_sign  = sa; mcand_mag  = MAG'(ma);
    mplier_sign = sb; mplier_mag = MAG'(mb);
    @(posedge clk);
    @(negedge clk);
    check("R2 busy after accept", busy, 1);
    if (junk_cycles > 0) begin
      in_valid = 1'b1;
      mcand_sign = ~sa; mcand_mag = ~MAG'(ma);
      mplier_sign = sb; mplier_mag = ~MAG'(mb);
    end else begin
      in_valid = 1'b0;
    end
    do begin
      @(posedge clk);
      cycles++;
      @(negedge clk);
      if (cycles == junk_cycles) in_valid = 1'b0;
      if (done) dones++;
    end while (!done && cycles < 4 * MAG);
    check("R6 latency", cycles, 2 * MAG);
    check("R4 sign", prod_sign, sa ^ sb);
    check("R5 magnitude", {prod_hi, prod_lo}, prod);
    if (junk_cycles > 0) check("R3 single done", dones, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 in_ready", in_ready, 1);
    check("R1 product", {prod_sign, prod_hi, prod_lo}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 in_ready after release", in_ready, 1);

    // R4 all sign pairs, including negative zero
    for (int s = 0; s < 4; s++) begin
      run_op(s[0], 0, s[1], 93, 0);
      run_op(s[0], 127, s[1], 127, 0);
      run_op(s[0], 55, s[1], 0, 0);
    end

    // R5 sweep: every multiplicand against spread multipliers (back-to-back, R8)
    for (int a = 0; a < 128; a++) begin
      for (int b = 0; b < 128; b += 9) begin
        run_op(a[0] ^ b[1], a, a[1], b, 0);
      end
      run_op(a[2], a, 1'b0, 127, 0);
    end

    // R8 back-to-back: in the done cycle in_ready must already be high
    check("R8 ready in done cycle", in_ready, 1);
    run_op(1'b1, 100, 1'b0, 3, 0);

    // R7 pulse and hold
    @(negedge clk);
    check("R7 done low after one cycle", done, 0);
    mcand_mag = 7'd11; mplier_mag = 7'd22; mcand_sign = 1'b1;
    repeat (5) @(negedge clk);
    check("R7 hold hi/lo", {prod_hi, prod_lo}, 300);
    check("R7 hold sign", prod_sign, 1);
    check("R7 still idle", busy, 0);

    // R3 offers while busy are ignored
    run_op(1'b0, 77, 1'b1, 45, 3);
    @(negedge clk);
    check("R3 no extra run", busy, 0);
    run_op(1'b1, 127, 1'b1, 1, 2 * MAG - 1);
    @(negedge clk);
    check("R3 no extra run late", busy, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule